// File: doc/BRIEF.md
# Burst Bi-Phase Mark Frame Encoder

This block turns a burst of NRZ serial data, delivered together with a bit clock that only toggles while valid data is present, into a Bi-Phase Mark line signal of fixed length. Each frame on the line is exactly `FRAME_BITS` (28 by default) bit cells long, and the line rests low whenever no frame is being sent.

Both inputs are asynchronous to the system clock. They are resynchronised, and data is sampled on each rising edge of the input bit clock. Bits collect in a frame store. A frame closes when the last bit position is filled, or when the bit clock has been silent for `GAP_CLKS` system clocks. Bit positions that were never filled are sent as zeros. A closed frame is handed to a cell encoder, which plays it out at a fixed rate of `2*HALF_CLKS` system clocks per bit cell. The system clock must run at least four times faster than the input bit rate. While a frame plays out, the next burst can already be collected.

Top module: `bpm_frame_encoder`

## Requirements
- R1: After reset, line_o and busy_o are both low.
- R2: Whenever busy_o is low, line_o is low.
- R3: Each bit cell lasts 2*HALF_CLKS system clocks and has two halves of HALF_CLKS clocks. line_o holds steady within a half and changes level at the start of every bit cell.
- R4: A one bit makes line_o change level again at the middle of its cell. A zero bit leaves it unchanged there.
- R5: Data is sampled at each rising edge of bit_clk_i. Bits go onto the line in the order they were sampled, so the first bit sampled is in the first cell.
- R6: A frame has exactly FRAME_BITS cells. busy_o rises with the first cell and falls one cell length after the start of the last cell. line_o is low from then on, even when the last cell ended high.
- R7: A burst of FRAME_BITS rising edges closes the frame at its last edge. busy_o stays low until that edge has been seen.
- R8: A burst with fewer edges closes GAP_CLKS system clocks after its last rising edge. The positions that were not sampled are sent as zeros.
- R9: A rising edge that arrives after a frame has closed begins a new frame. Consecutive frames are separated by at least one system clock with busy_o and line_o low.
- R10: A change on bit_dat_i with no rising edge on bit_clk_i produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the input bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk_i | input | 1 | Gated NRZ bit clock, asynchronous, low between bursts |
| bit_dat_i | input | 1 | NRZ data, asynchronous, sampled on rising edges of bit_clk_i |
| line_o | output | 1 | Bi-Phase Mark encoded line, low between frames |
| busy_o | output | 1 | High while a frame is on the line |

## Verification
A wrong half-cell counter shows up within the first cell as a transition off the HALF_CLKS grid, or as a missing level change at a cell boundary. A wrong bit index or a wrong shift shows up as a misdecoded bit, or a bit in the wrong position, in the frame that follows. A wrong bit count or gap count shows up as a frame of the wrong length, or one that closes at the wrong time. A stuck state shows up as a frame that never ends or never starts, and a wrong end-of-frame path leaves the line high after busy_o falls. All of these appear at the ports within a single frame, so decoding every half cell of each frame exposes them before the next frame begins.

// File: rtl/bpm_enc_pkg.sv
// Shared state types for the burst Bi-Phase Mark frame encoder.
package bpm_enc_pkg;

    // Frame store states: waiting, collecting bits, holding a closed frame.
    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_COLLECT = 2'd1,
        CAP_HOLD    = 2'd2
    } cap_state_e;

    // Cell encoder states.
    typedef enum logic {
        ENC_IDLE = 1'b0,
        ENC_RUN  = 1'b1
    } enc_state_e;

endpackage

// File: rtl/bpm_edge_sync.sv
// Resynchronises the asynchronous bit clock and data into the system clock
// domain and flags rising edges of the bit clock.
// Assumes: both inputs hold each level for at least two system clocks.
// Data passes through the same number of stages as the clock, so the
// sampled bit lines up with the detected edge.
module bpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk_i,
    input  logic bit_dat_i,
    output logic rise_o,
    output logic dat_o
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_prev;

    // Synchroniser chains, one flop per stage.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_pipe[0] <= 1'b0;
                        dat_pipe[0] <= 1'b0;
                    end else begin
                        clk_pipe[0] <= bit_clk_i;
                        dat_pipe[0] <= bit_dat_i;
                    end
                end
            end else begin : g_next
                // Later stages settle the captured levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_pipe[s] <= 1'b0;
                        dat_pipe[s] <= 1'b0;
                    end else begin
                        clk_pipe[s] <= clk_pipe[s-1];
                        dat_pipe[s] <= dat_pipe[s-1];
                    end
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= clk_pipe[STAGES-1];
    end

    // Rising edge flag and the data bit that belongs to it.
    always_comb begin
        rise_o = clk_pipe[STAGES-1] & ~clk_prev;
        dat_o  = dat_pipe[STAGES-1];
    end

endmodule

// File: rtl/bpm_frame_capture.sv
// Collects sampled bits into a frame store. The frame closes when the last
// bit position is filled, or after GAP_CLKS clocks without a bit-clock edge.
// Unfilled positions stay zero. A closed frame is held until the encoder
// takes it, and edges seen while holding are dropped.
// Assumes: FRAME_BITS >= 2, GAP_CLKS >= 2.
module bpm_frame_capture
    import bpm_enc_pkg::*;
#(
    parameter int FRAME_BITS = 28,
    parameter int GAP_CLKS   = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise_i,
    input  logic                  dat_i,
    input  logic                  take_i,
    output logic                  ready_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CLKS - 1);

    cap_state_e            state;
    logic [IDX_W-1:0]      nbits;
    logic [GAP_W-1:0]      gap;
    logic [FRAME_BITS-1:0] store;

    // Frame collection state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            nbits <= '0;
            gap   <= '0;
            store <= '0;
        end else begin
            case (state)
                CAP_IDLE: begin
                    if (rise_i) begin
                        store    <= '0;
                        store[0] <= dat_i;
                        nbits    <= IDX_W'(1);
                        gap      <= '0;
                        state    <= CAP_COLLECT;
                    end
                end
                CAP_COLLECT: begin
                    if (rise_i) begin
                        store[nbits] <= dat_i;
                        gap          <= '0;
                        if (nbits == LAST_IDX) state <= CAP_HOLD;
                        else                   nbits <= nbits + 1'b1;
                    end else if (gap == GAP_LAST) begin
                        state <= CAP_HOLD;
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
                CAP_HOLD: begin
                    if (take_i) begin
                        state <= CAP_IDLE;
                        nbits <= '0;
                        gap   <= '0;
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // Hand-off view of the closed frame.
    always_comb begin
        ready_o = (state == CAP_HOLD);
        frame_o = store;
    end

    AST_TAKE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> ready_o);  // R9
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_COLLECT) |-> (gap < GAP_W'(GAP_CLKS)));  // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_COLLECT && rise_i && nbits == LAST_IDX) |=> ready_o);  // R7

endmodule

// File: rtl/bpm_cell_encoder.sv
// Plays a closed frame onto the line as Bi-Phase Mark cells of 2*HALF_CLKS
// clocks. The line changes level at each cell start, and again at mid-cell
// for a one. After the last cell the line is forced low and busy drops.
// Assumes: the line is low on entry (idle), HALF_CLKS >= 2.
module bpm_cell_encoder
    import bpm_enc_pkg::*;
#(
    parameter int FRAME_BITS = 28,
    parameter int HALF_CLKS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ready_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic                  take_o,
    output logic                  line_o,
    output logic                  busy_o
);
    localparam int HC_W   = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int HALF_W = $clog2(2 * FRAME_BITS);
    localparam logic [HC_W-1:0]   HC_LAST   = HC_W'(HALF_CLKS - 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * FRAME_BITS - 1);

    enc_state_e            state;
    logic [FRAME_BITS-1:0] shreg;
    logic [HC_W-1:0]       hcnt;
    logic [HALF_W-1:0]     half;
    logic                  line_q;

    // Accept a frame only while the line is idle.
    always_comb begin
        take_o = (state == ENC_IDLE) && ready_i;
        line_o = line_q;
        busy_o = (state == ENC_RUN);
    end

    // Half-cell timing and line level generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENC_IDLE;
            shreg  <= '0;
            hcnt   <= '0;
            half   <= '0;
            line_q <= 1'b0;
        end else begin
            case (state)
                ENC_IDLE: begin
                    if (ready_i) begin
                        shreg  <= frame_i;
                        hcnt   <= '0;
                        half   <= '0;
                        line_q <= ~line_q;
                        state  <= ENC_RUN;
                    end
                end
                ENC_RUN: begin
                    if (hcnt == HC_LAST) begin
                        hcnt <= '0;
                        if (!half[0]) begin
                            line_q <= line_q ^ shreg[0];
                            half   <= half + 1'b1;
                        end else if (half == HALF_LAST) begin
                            line_q <= 1'b0;
                            state  <= ENC_IDLE;
                        end else begin
                            line_q <= ~line_q;
                            shreg  <= shreg >> 1;
                            half   <= half + 1'b1;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: state <= ENC_IDLE;
            endcase
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_o);  // R2
    AST_HALF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hcnt != '0) |-> $stable(line_o));  // R3
    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hcnt == '0 && !half[0]) |-> (line_o != $past(line_o)));  // R3
    AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !line_o);  // R6

endmodule

// File: rtl/bpm_frame_encoder.sv
// Top of the burst Bi-Phase Mark frame encoder: resynchronisation, frame
// collection with zero padding, and fixed-length cell encoding.
// Assumes: system clock at least four times the input bit rate.
module bpm_frame_encoder #(
    parameter int FRAME_BITS  = 28,
    parameter int HALF_CLKS   = 4,
    parameter int GAP_CLKS    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk_i,
    input  logic bit_dat_i,
    output logic line_o,
    output logic busy_o
);
    logic                  rise;
    logic                  dat;
    logic                  ready;
    logic                  take;
    logic [FRAME_BITS-1:0] frame;

    bpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_clk_i (bit_clk_i),
        .bit_dat_i (bit_dat_i),
        .rise_o    (rise),
        .dat_o     (dat)
    );

    bpm_frame_capture #(.FRAME_BITS(FRAME_BITS), .GAP_CLKS(GAP_CLKS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .dat_i   (dat),
        .take_i  (take),
        .ready_o (ready),
        .frame_o (frame)
    );

    bpm_cell_encoder #(.FRAME_BITS(FRAME_BITS), .HALF_CLKS(HALF_CLKS)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (ready),
        .frame_i (frame),
        .take_o  (take),
        .line_o  (line_o),
        .busy_o  (busy_o)
    );

endmodule

// File: tb/bpm_frame_encoder_test.sv
// Directed bench: each task drives one scenario and checks the decoded line.
module bpm_frame_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 28;
    localparam int HALF_CLKS  = 4;
    localparam int GAP_CLKS   = 64;
    localparam int BIT_HALF   = 6;   // system clocks per input clock level
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_clk_i = 1'b0;
    logic bit_dat_i = 1'b0;
    logic line_o;
    logic busy_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bpm_frame_encoder #(
        .FRAME_BITS(FRAME_BITS), .HALF_CLKS(HALF_CLKS),
        .GAP_CLKS(GAP_CLKS), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bit_clk_i(bit_clk_i), .bit_dat_i(bit_dat_i),
        .line_o(line_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Drive n bits, LSB first, one per input clock period.
    // chk_last: check busy is still low right before the final edge (R7).
    // chk_gap: after the burst, check busy stays low for most of the gap (R8).
    task automatic send_bits(input logic [63:0] bits, input int n,
                             input bit chk_last, input bit chk_gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bit_dat_i = bits[i];
            repeat (BIT_HALF) @(posedge clk);
            if (chk_last && i == n - 1) begin
                @(negedge clk);
                check(busy_o == 1'b0, "R7 busy before last edge", 64'(busy_o), 64'd0);
                @(posedge clk);
            end
            #1 bit_clk_i = 1'b1;
            repeat (BIT_HALF) @(posedge clk);
            #1 bit_clk_i = 1'b0;
        end
        @(posedge clk); #1;
        bit_dat_i = 1'b0;
        if (chk_gap) begin
            bit gap_ok = 1'b1;
            for (int k = 0; k < GAP_CLKS - 24; k++) begin
                @(negedge clk);
                if (busy_o) gap_ok = 1'b0;
            end
            check(gap_ok, "R8 busy low during gap", 64'(!gap_ok), 64'd0);
        end
    endtask

    // Wait for a frame, sample every half cell and decode it.
    task automatic recv_frame(input logic [27:0] exp, input string name);
        logic [2*FRAME_BITS-1:0] h;
        logic [27:0] got;
        bit steady = 1'b1;
        bit bound_ok = 1'b1;
        bit seen = 1'b0;
        logic prev;
        for (int w = 0; w < 4000 && !seen; w++) begin
            @(negedge clk);
            if (busy_o) seen = 1'b1;
        end
        check(seen, {"R6 frame start ", name}, 64'(seen), 64'd1);
        if (!seen) return;
        for (int j = 0; j < 2 * FRAME_BITS; j++) begin
            for (int k = 0; k < HALF_CLKS; k++) begin
                if (k == 0) h[j] = line_o;
                else if (line_o != h[j]) steady = 1'b0;
                if (!busy_o) steady = 1'b0;
                @(negedge clk);
            end
        end
        prev = 1'b0;
        for (int i = 0; i < FRAME_BITS; i++) begin
            if (h[2*i] == prev) bound_ok = 1'b0;
            got[i] = h[2*i] ^ h[2*i+1];
            prev = h[2*i+1];
        end
        check(steady, {"R3 half-cell steady ", name}, 64'(steady), 64'd1);
        check(bound_ok, {"R3 cell boundary edge ", name}, 64'(bound_ok), 64'd1);
        check(got == exp, {"R4 R5 decoded bits ", name}, 64'(got), 64'(exp));
        check(busy_o == 1'b0 && line_o == 1'b0, {"R6 end low ", name},
              {62'd0, busy_o, line_o}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(line_o == 1'b0 && busy_o == 1'b0, "R1 reset state",
              {62'd0, busy_o, line_o}, 64'd0);
    endtask

    task automatic t_full(input logic [27:0] pat, input string name);
        fork
            send_bits(64'(pat), FRAME_BITS, 1'b1, 1'b0);
            recv_frame(pat, name);
        join
    endtask

    task automatic t_short;
        // R8: five bits 1,1,1,0,1 then silence, padded with zeros
        fork
            send_bits(64'h17, 5, 1'b0, 1'b1);
            recv_frame(28'h17, "short");
        join
    endtask

    task automatic t_single;
        // R8: one isolated clock pulse carrying a one
        fork
            send_bits(64'h1, 1, 1'b0, 1'b0);
            recv_frame(28'h1, "single");
        join
    endtask

    task automatic t_overrun;
        // R9: 30 edges give a full frame, then a 2-bit frame; R2 gap between
        logic [63:0] bits = 64'h2_9C3A_5B1;
        fork
            send_bits(bits, 30, 1'b0, 1'b0);
            begin
                recv_frame(bits[27:0], "overrun first");
                check(busy_o == 1'b0 && line_o == 1'b0, "R9 idle cycle between",
                      {62'd0, busy_o, line_o}, 64'd0);
                recv_frame(28'(bits[29:28]), "overrun second");
            end
        join
    endtask

    task automatic t_data_only;
        // R10: data toggles with the bit clock held low
        bit quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            bit_dat_i = ~bit_dat_i;
            repeat (3) begin
                @(negedge clk);
                if (busy_o || line_o) quiet = 1'b0;
            end
        end
        bit_dat_i = 1'b0;
        for (int k = 0; k < 2 * GAP_CLKS; k++) begin
            @(negedge clk);
            if (busy_o || line_o) quiet = 1'b0;
        end
        check(quiet, "R10 data without clock ignored", 64'(!quiet), 64'd0);
        check(line_o == 1'b0, "R2 idle line low", 64'(line_o), 64'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_full(28'hA5C30F1, "mixed");
        t_full(28'h0000001, "odd ones ends high");
        t_full(28'hFFFFFFF, "all ones");
        t_full(28'h0000000, "all zeros");
        t_short();
        t_single();
        t_overrun();
        t_data_only();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule